// File: doc/BRIEF.md
# Pin Configuration Bank with Pin Interrupt Detection

This block holds one configuration word per pin for a small group of general-purpose pins. Each word selects the pin's function, sets its drive-strength, open-drain and input-filter enables, and chooses an interrupt condition. The bank does not drive pads or route peripherals. It exports the configuration bits to the pad ring and the function multiplexer, which act on them. A lock bit in each word makes the lower sixteen bits of that word read-only until reset. The interrupt-condition field stays writable after lock.

Each pin input passes through a synchronizer. The synchronized value is compared with its value one cycle earlier to find edges, or it is sampled directly for the level condition. A match sets a sticky per-pin status flag, and software clears a flag by writing 1 to its bit. The OR of all flags forms a single interrupt line. Software reaches the bank through a plain word-addressed write strobe and a combinational read port. No streaming data path exists, so there is no valid/ready handshake.

Top module: `pin_ctrl_bank`

## Requirements
- R1: A word whose lock bit (bit 15) is 1 ignores writes to bits [15:0] until reset, and its exported configuration bits stay unchanged.
- R2: A write to pin word n (word address n, n < NUM_PINS) whose lock bit is 0 updates the lock (bit 15), function select (bits [10:8]), drive-strength (bit 6), open-drain (bit 5) and filter (bit 4) fields.
- R3: Reading pin word n returns only the implemented fields at those positions plus bits [19:16]. All other bits read 0, and writing them has no effect.
- R4: The interrupt-condition field, bits [19:16], takes every write whether or not the word is locked.
- R5: Code 1001 sets pin n's flag on a 0-to-1 change of the synchronized input. Code 1010 sets it on a 1-to-0 change. Code 1011 sets it on either change.
- R6: Code 1100 sets the flag on every cycle that the synchronized input is 1. A clear in such a cycle leaves the flag set.
- R7: Code 0000 and every code other than 1001, 1010, 1011 and 1100 never sets a flag.
- R8: While a pin's function select is 000, that pin never sets its flag.
- R9: The status word sits at word address NUM_PINS, with bit n holding pin n's flag. Writing 1 to a bit clears that flag, writing 0 leaves it unchanged, and a flag otherwise stays set.
- R10: irq_out is the OR of all flags. When an input change is held from before a rising clock edge, irq_out is high after the third edge and low after the second.
- R11: After reset, every word and flag is 0, irq_out is 0 and every exported configuration output is 0. The outputs pin_mux, pin_drive, pin_odrain and pin_filt follow the stored fields.
- R12: A read of a word address above NUM_PINS returns 0, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | ADDR_W | Word address: pins 0..NUM_PINS-1, status at NUM_PINS |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_mux | output | 3*NUM_PINS | Function select per pin, pin n at [3n+2:3n] |
| pin_drive | output | NUM_PINS | Drive-strength enable per pin |
| pin_odrain | output | NUM_PINS | Open-drain enable per pin |
| pin_filt | output | NUM_PINS | Input filter enable per pin |
| irq_out | output | 1 | OR of all pin status flags |

## Verification
The register table writes all-ones, sparse and reserved-only patterns. This separates implemented bits from reserved ones and shows that an out-of-range address is ignored. The interrupt tests drive a single pin through a rise, a fall and a rise-then-fall under each condition code. This distinguishes rising, falling and either-edge detection and shows that the level condition re-asserts while the pin stays high. The same toggles under a reserved code and under function select 000 must leave the flags at 0. A sample after the second and after the third edge pins down the detection latency.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int LOCK_BIT = 15;
  localparam int MUX_LSB  = 8;
  localparam int DSE_BIT  = 6;
  localparam int ODE_BIT  = 5;
  localparam int PFE_BIT  = 4;
  localparam int IRQ_LSB  = 16;

  localparam logic [31:0] IMPL_MASK = 32'h000F_8770;

  typedef enum logic [3:0] {
    IRQ_OFF  = 4'h0,
    IRQ_RISE = 4'h9,
    IRQ_FALL = 4'hA,
    IRQ_BOTH = 4'hB,
    IRQ_HIGH = 4'hC
  } irq_mode_e;

  typedef struct packed {
    logic       lock;
    logic [2:0] mux;
    logic       dse;
    logic       ode;
    logic       pfe;
    logic [3:0] irqc;
  } pin_cfg_t;

  function automatic logic [31:0] pack_cfg(input pin_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[IRQ_LSB+:4]  = c.irqc;
    w[LOCK_BIT]    = c.lock;
    w[MUX_LSB+:3]  = c.mux;
    w[DSE_BIT]     = c.dse;
    w[ODE_BIT]     = c.ode;
    w[PFE_BIT]     = c.pfe;
    return w;
  endfunction
endpackage

// File: rtl/pcr_reg.sv
module pcr_reg
  import pcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output pin_cfg_t    cfg
);
  logic reserved_unused;
  assign reserved_unused = ^{wdata[31:20], wdata[14:11], wdata[7], wdata[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.irqc <= wdata[IRQ_LSB+:4];
      if (!cfg.lock) begin
        cfg.lock <= wdata[LOCK_BIT];
        cfg.mux  <= wdata[MUX_LSB+:3];
        cfg.dse  <= wdata[DSE_BIT];
        cfg.ode  <= wdata[ODE_BIT];
        cfg.pfe  <= wdata[PFE_BIT];
      end
    end
  end

  // R1: once locked, the lower half never changes
  assert_lock_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.lock |=> $stable({cfg.lock, cfg.mux, cfg.dse, cfg.ode, cfg.pfe}));

  // R4: interrupt condition follows every write
  assert_irqc_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg.irqc == $past(wdata[IRQ_LSB+:4])));
endmodule

// File: rtl/pin_detect.sv
module pin_detect
  import pcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic [3:0] mode,
  input  logic       enable,
  output logic       evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   now_lvl;
  logic                   hit;

  assign now_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      prev_q <= now_lvl;
    end
  end

  always_comb begin
    case (mode)
      IRQ_RISE: hit = now_lvl & ~prev_q;
      IRQ_FALL: hit = ~now_lvl & prev_q;
      IRQ_BOTH: hit = now_lvl ^ prev_q;
      IRQ_HIGH: hit = now_lvl;
      default:  hit = 1'b0;
    endcase
  end

  assign evt = enable & hit;

  // R8: a disabled pin raises nothing
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !evt);

  // R7: reserved codes raise nothing
  assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode inside {IRQ_RISE, IRQ_FALL, IRQ_BOTH, IRQ_HIGH}) |-> !evt);

  // R5: a rising-mode event needs a new high level
  assert_rise_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode == IRQ_RISE) |-> (now_lvl && !$past(now_lvl)));
endmodule

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank
  import pcr_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [3*NUM_PINS-1:0] pin_mux,
  output logic [NUM_PINS-1:0]   pin_drive,
  output logic [NUM_PINS-1:0]   pin_odrain,
  output logic [NUM_PINS-1:0]   pin_filt,
  output logic                  irq_out
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);

  pin_cfg_t            cfg_arr [NUM_PINS];
  logic [NUM_PINS-1:0] evt_vec;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] clr_vec;
  logic                stat_wr;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic wr_sel;
    assign wr_sel = bus_wr && (bus_addr == ADDR_W'(i));

    pcr_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_sel),
      .wdata (bus_wdata),
      .cfg   (cfg_arr[i])
    );

    pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in[i]),
      .mode   (cfg_arr[i].irqc),
      .enable (cfg_arr[i].mux != 3'b000),
      .evt    (evt_vec[i])
    );

    assign pin_mux[3*i+:3] = cfg_arr[i].mux;
    assign pin_drive[i]    = cfg_arr[i].dse;
    assign pin_odrain[i]   = cfg_arr[i].ode;
    assign pin_filt[i]     = cfg_arr[i].pfe;
  end

  assign stat_wr = bus_wr && (bus_addr == STAT_ADDR);
  assign clr_vec = stat_wr ? bus_wdata[NUM_PINS-1:0] : '0;

  // set wins over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_vec) | evt_vec;
  end

  assign irq_out = |flag_q;

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bus_addr == ADDR_W'(p)) bus_rdata = pack_cfg(cfg_arr[p]);
    end
    if (bus_addr == STAT_ADDR) bus_rdata[NUM_PINS-1:0] = flag_q;
  end

  // R9: flags are sticky without a status write
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R10: the interrupt line only rises after a detected event
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(|evt_vec));

  // R3: reserved bits of pin words read zero
  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < STAT_ADDR) |-> ((bus_rdata & ~IMPL_MASK) == 32'h0));
endmodule

// File: tb/sim_pin_ctrl_bank.sv
module sim_pin_ctrl_bank;
  localparam int NP = 4;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [3*NP-1:0] pin_mux;
  logic [NP-1:0] pin_drive, pin_odrain, pin_filt;
  logic          irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_ctrl_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_mux(pin_mux), .pin_drive(pin_drive), .pin_odrain(pin_odrain),
    .pin_filt(pin_filt), .irq_out(irq_out)
  );

  // {addr, write data, expected read}
  localparam logic [66:0] VEC [6] = '{
    {3'd0, 32'hFFFF_7FFF, 32'h000F_0770},  // R2 R3 all ones, unlocked
    {3'd1, 32'h0001_0123, 32'h0001_0120},  // R2 R3 sparse
    {3'd2, 32'h0000_0250, 32'h0000_0250},  // R2
    {3'd3, 32'h00A0_0000, 32'h0000_0000},  // R3 reserved only
    {3'd0, 32'h0000_0000, 32'h0000_0000},  // R2 back to zero
    {3'd7, 32'hFFFF_FFFF, 32'h0000_0000}   // R12 out of range
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic stat_is(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(3'd4, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    cyc(2);
    // R11 reset state
    rd(3'd0, v); chk("R11 word0 reset", v, 32'h0);
    chk("R11 irq reset", {31'h0, irq_out}, 32'h0);
    chk("R11 mux reset", {20'h0, pin_mux}, 32'h0);
    rst_n = 1'b1;
    cyc(1);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], v);
      chk($sformatf("R2/R3/R12 vector %0d", i), v, VEC[i][31:0]);
    end
    // R12 out-of-range write touched nothing
    rd(3'd2, v); chk("R12 word2 intact", v, 32'h0000_0250);
    chk("R11 exports", {16'h0, pin_drive, pin_odrain, pin_filt},
        {16'h0, 4'b0100, 4'b0010, 4'b0100});

    // R1 lock, R4 irqc still open
    wr(3'd1, 32'h0000_8100);
    rd(3'd1, v); chk("R1 lock set", v, 32'h0000_8100);
    wr(3'd1, 32'h0009_0670);
    rd(3'd1, v); chk("R4 irqc after lock", v, 32'h0009_8100);
    wr(3'd1, 32'h0000_0000);
    rd(3'd1, v); chk("R1 lower frozen", v, 32'h0000_8100);
    chk("R1 mux export", {29'h0, pin_mux[5:3]}, 32'h1);

    // R5 rising, with R10 latency
    wr(3'd0, 32'h0009_0100);
    pin_in[0] = 1'b1;
    cyc(2); chk("R10 irq low after 2", {31'h0, irq_out}, 32'h0);
    cyc(1); chk("R10 irq high after 3", {31'h0, irq_out}, 32'h1);
    stat_is("R5 rise flag", 32'h1);
    wr(3'd4, 32'h0);
    stat_is("R9 write 0 keeps", 32'h1);
    wr(3'd4, 32'h1);
    stat_is("R9 clear", 32'h0);
    chk("R10 irq cleared", {31'h0, irq_out}, 32'h0);

    // R5 falling
    wr(3'd0, 32'h000A_0100);
    pin_in[0] = 1'b0; cyc(4);
    stat_is("R5 fall flag", 32'h1);
    wr(3'd4, 32'h1);
    // R5 rising ignored in fall mode
    pin_in[0] = 1'b1; cyc(4);
    stat_is("R5 rise ignored in fall mode", 32'h0);

    // R5 either edge
    wr(3'd0, 32'h000B_0100);
    pin_in[0] = 1'b0; cyc(4);
    stat_is("R5 both fall", 32'h1);
    wr(3'd4, 32'h1);
    pin_in[0] = 1'b1; cyc(4);
    stat_is("R5 both rise", 32'h1);
    wr(3'd4, 32'h1);

    // R6 level high
    wr(3'd0, 32'h000C_0100);
    cyc(1);
    stat_is("R6 level flag", 32'h1);
    wr(3'd4, 32'h1);
    stat_is("R6 reasserts while high", 32'h1);
    pin_in[0] = 1'b0; cyc(4);
    wr(3'd4, 32'h1);
    stat_is("R6 clears when low", 32'h0);

    // R7 reserved code
    wr(3'd0, 32'h000D_0100);
    pin_in[0] = 1'b1; cyc(4); pin_in[0] = 1'b0; cyc(4);
    stat_is("R7 reserved code", 32'h0);

    // R8 function select 000
    wr(3'd0, 32'h0009_0000);
    pin_in[0] = 1'b1; cyc(4);
    stat_is("R8 disabled pin", 32'h0);
    chk("R8 irq quiet", {31'h0, irq_out}, 32'h0);

    // R9 selective clear, two pins flagged
    pin_in = '0; cyc(4);
    wr(3'd0, 32'h0009_0100);
    wr(3'd2, 32'h0009_0200);
    pin_in[0] = 1'b1; pin_in[2] = 1'b1; cyc(4);
    stat_is("R9 two flags", 32'h5);
    wr(3'd4, 32'h4);
    stat_is("R9 only bit2 cleared", 32'h1);
    chk("R10 irq from remaining flag", {31'h0, irq_out}, 32'h1);

    // R1 lock released only by reset
    rst_n = 1'b0; cyc(1); rst_n = 1'b1; cyc(1);
    wr(3'd1, 32'h0000_0300);
    rd(3'd1, v); chk("R1 unlocked after reset", v, 32'h0000_0300);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule